// File: doc/BRIEF.md
# Auto-Polling MDIO Management Master

This block drives the two-wire station management bus used to reach Ethernet PHYs. It produces the management clock from the system clock and serialises 64-bit management frames. Each frame is a preamble of ones, a start pattern, an opcode, a PHY address, a register address, a turnaround and a 16-bit data field. The enable output releases the data line whenever the PHY must drive it. The open-drain pad sits outside the block.

When the host is idle, the block keeps reading four standard registers (0, 1, 4 and 5) on each managed port. From those reads it keeps a per-port view of link state, speed and duplex. A host can read or write any register on any managed port. The request is latched, served at the next frame boundary, and answered with a done pulse and, for reads, the returned data. Polling then continues from where it stopped.

Top module: `mdio_poll_master`

## Requirements
- R1: Every frame is 64 MDC cycles: 32 ones, start bits 0 then 1, opcode bits 1,0 for a read or 0,1 for a write, then the 5-bit PHY address and the 5-bit register address, each MSB first.
- R2: MDC stays high for exactly DIV_HALF system clocks per cycle and low for at least DIV_HALF. mdioOut and mdioOe change only while MDC is low.
- R3: In a read frame, mdioOe is low for bit positions 46 to 63 (turnaround and data). mdioIn is sampled at each MDC rising edge of bits 48 to 63, MSB first, to form the read data.
- R4: In a write frame, the master drives the turnaround as 1 then 0, followed by the 16 data bits MSB first.
- R5: With no host request, the master issues read frames for port 0 to NUM_PORTS-1 in order, reading registers 0, 1, 4 and 5 of each port in that order, and then wraps to port 0.
- R6: Port p is addressed as PHY address PHY_BASE+p, both for polling and for host access.
- R7: linkUp[p] equals bit 2 of the most recent register 1 value polled from port p.
- R8: When bit 12 of port p's polled register 0 is set, speed100[p] and fullDuplex[p] come from the highest bit set in (register 4 AND register 5) bits 8..5. Bit 8 gives 100 full, bit 7 gives 100 half, bit 6 gives 10 full, bit 5 gives 10 half, and no common bit gives 10 half. Both are updated when register 5 is polled.
- R9: When bit 12 of port p's polled register 0 is clear, speed100[p] takes register 0 bit 13 and fullDuplex[p] takes register 0 bit 8.
- R10: A request is taken when hostReq is high and hostBusy is low, and hostBusy rises on the next cycle. A request made while busy is ignored. hostDone pulses for one cycle in the cycle hostBusy falls, and hostRdata holds the read data from that cycle on.
- R11: A taken request is issued as the next frame. The frame after it is the poll frame that would have followed the last poll before it.
- R12: In reset, mdc, mdioOe, hostBusy, hostDone and all status outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host request strobe |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostPort | input | PORT_W | Target port index |
| hostReg | input | 5 | Target register address |
| hostWdata | input | 16 | Write data |
| hostBusy | output | 1 | Request held or in progress |
| hostDone | output | 1 | One-cycle completion pulse |
| hostRdata | output | 16 | Data of the last host read |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data driven value |
| mdioOe | output | 1 | Management data drive enable |
| mdioIn | input | 1 | Management data line value |
| linkUp | output | NUM_PORTS | Per-port link status |
| fullDuplex | output | NUM_PORTS | Per-port duplex (1 = full) |
| speed100 | output | NUM_PORTS | Per-port speed (1 = 100 Mb/s) |

## Verification
The bench sweeps every port through many arithmetic combinations of abilities, auto-negotiation enable and forced bits. A wrong priority order, or a mask taken from only one register, would report the wrong speed or duplex. A PHY model that reacts only to MDC edges checks the frame fields, the turnaround and the release of the line. An off-by-one in the bit counter would break the start pattern or shift the read data. A request made while busy must leave the model's registers untouched. The frame after a host access must continue the poll sequence; a design that restarts polling, or skips an entry, fails that check.

// File: rtl/mdio_poll_pkg.sv
package mdio_poll_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int POLL_SLOTS = 4;

  // Control -> datapath: one frame request
  typedef struct packed {
    logic        start;
    logic        isRead;
    logic [4:0]  phyAddr;
    logic [4:0]  regAddr;
    logic [15:0] wrData;
  } mdioCmd_t;

  // Datapath -> control: frame completion
  typedef struct packed {
    logic        done;
    logic [15:0] rdData;
  } mdioRsp_t;

  // Poll slot index to register number (0, 1, 4, 5)
  function automatic logic [4:0] pollRegOf(input logic [1:0] slot);
    case (slot)
      2'd0:    return 5'd0;
      2'd1:    return 5'd1;
      2'd2:    return 5'd4;
      default: return 5'd5;
    endcase
  endfunction

endpackage

// File: rtl/mdio_poll_resolve.sv
module mdio_poll_resolve (
  input  logic       autoNeg,
  input  logic       forceSpd,
  input  logic       forceFull,
  input  logic [3:0] localAbil,   // register 4 bits 8..5
  input  logic [3:0] peerAbil,    // register 5 bits 8..5
  output logic       speed100,
  output logic       fullDuplex
);
  logic [3:0] common;

  always_comb begin
    common = localAbil & peerAbil;
    if (!autoNeg) begin
      speed100   = forceSpd;
      fullDuplex = forceFull;
    end else if (common[3]) begin
      speed100   = 1'b1;
      fullDuplex = 1'b1;
    end else if (common[2]) begin
      speed100   = 1'b1;
      fullDuplex = 1'b0;
    end else if (common[1]) begin
      speed100   = 1'b0;
      fullDuplex = 1'b1;
    end else begin
      speed100   = 1'b0;
      fullDuplex = 1'b0;
    end
  end
endmodule

// File: rtl/mdio_poll_dpath.sv
module mdio_poll_dpath
  import mdio_poll_pkg::*;
#(
  parameter int DIV_HALF = 10
) (
  input  logic     clk,
  input  logic     rstN,
  input  mdioCmd_t cmd,
  output mdioRsp_t rsp,
  output logic     mdc,
  output logic     mdioOut,
  output logic     mdioOe,
  input  logic     mdioIn
);
  localparam int DIVW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(DIV_HALF - 1);

  logic [DIVW-1:0] divCnt;
  logic            running;
  logic            rdMode;
  logic [5:0]      bitIdx;
  logic [63:0]     frameReg;
  logic [63:0]     frameBits;
  logic [15:0]     rdShift;
  logic            doneQ;
  logic            halfTick;

  assign halfTick = running && (divCnt == DIV_LAST);
  assign rsp      = '{done: doneQ, rdData: rdShift};

  always_comb begin
    frameBits = {32'hFFFF_FFFF, 2'b01,
                 cmd.isRead ? 2'b10 : 2'b01,
                 cmd.phyAddr, cmd.regAddr,
                 cmd.isRead ? 2'b11 : 2'b10,
                 cmd.isRead ? 16'hFFFF : cmd.wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      running  <= 1'b0;
      rdMode   <= 1'b0;
      bitIdx   <= '0;
      frameReg <= '0;
      rdShift  <= '0;
      doneQ    <= 1'b0;
      mdc      <= 1'b0;
      mdioOut  <= 1'b0;
      mdioOe   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!running) begin
        divCnt <= '0;
        if (cmd.start) begin
          running  <= 1'b1;
          frameReg <= frameBits;
          rdMode   <= cmd.isRead;
          bitIdx   <= '0;
          mdioOe   <= 1'b1;
          mdioOut  <= frameBits[63];
        end
      end else begin
        divCnt <= halfTick ? '0 : divCnt + 1'b1;
        if (halfTick) begin
          if (!mdc) begin
            mdc <= 1'b1;
            if (rdMode && bitIdx >= 6'(DATA_POS))
              rdShift <= {rdShift[14:0], mdioIn};
          end else begin
            mdc <= 1'b0;
            if (bitIdx == 6'(FRAME_BITS - 1)) begin
              running <= 1'b0;
              mdioOe  <= 1'b0;
              mdioOut <= 1'b0;
              doneQ   <= 1'b1;
            end else begin
              bitIdx  <= bitIdx + 6'd1;
              mdioOut <= frameReg[6'd62 - bitIdx];
              mdioOe  <= !(rdMode && (bitIdx + 6'd1 >= 6'(TA_POS)));
            end
          end
        end
      end
    end
  end

  // MDC high-phase length counter for checking
  logic [DIVW:0] highCnt;
  always_ff @(posedge clk) begin
    if (!rstN) highCnt <= '0;
    else       highCnt <= mdc ? highCnt + 1'b1 : '0;
  end

  p_quiet_while_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    mdc |-> ($stable(mdioOut) && $stable(mdioOe)));

  p_high_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mdc) |-> (highCnt == (DIVW+1)'(DIV_HALF)));

  p_release_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (running && rdMode && bitIdx >= 6'(TA_POS)) |-> !mdioOe);

  p_start_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.start && !running) |=> (running && mdioOe && !mdc));

endmodule

// File: rtl/mdio_poll_ctrl.sv
module mdio_poll_ctrl
  import mdio_poll_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PHY_BASE  = 1,
  parameter int PORT_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostReq,
  input  logic                 hostWrite,
  input  logic [PORT_W-1:0]    hostPort,
  input  logic [4:0]           hostReg,
  input  logic [15:0]          hostWdata,
  output logic                 hostBusy,
  output logic                 hostDone,
  output logic [15:0]          hostRdata,
  output mdioCmd_t             cmd,
  input  mdioRsp_t             rsp,
  output logic [NUM_PORTS-1:0] linkUp,
  output logic [NUM_PORTS-1:0] fullDuplex,
  output logic [NUM_PORTS-1:0] speed100
);
  localparam logic [PORT_W-1:0] LAST_PORT = PORT_W'(NUM_PORTS - 1);

  typedef enum logic {S_LAUNCH, S_WAIT} state_t;

  state_t            state;
  logic              curHost;
  logic              hPend;
  logic              hWr;
  logic [PORT_W-1:0] hPort;
  logic [4:0]        hReg;
  logic [15:0]       hData;
  logic [PORT_W-1:0] pollPort;
  logic [1:0]        pollSlot;
  logic              pollDone;

  assign hostBusy = hPend;
  assign pollDone = (state == S_WAIT) && rsp.done && !curHost;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_LAUNCH;
      curHost   <= 1'b0;
      hPend     <= 1'b0;
      hWr       <= 1'b0;
      hPort     <= '0;
      hReg      <= '0;
      hData     <= '0;
      pollPort  <= '0;
      pollSlot  <= '0;
      hostDone  <= 1'b0;
      hostRdata <= '0;
      cmd       <= '0;
    end else begin
      hostDone  <= 1'b0;
      cmd.start <= 1'b0;
      if (hostReq && !hPend) begin
        hPend <= 1'b1;
        hWr   <= hostWrite;
        hPort <= hostPort;
        hReg  <= hostReg;
        hData <= hostWdata;
      end
      case (state)
        S_LAUNCH: begin
          cmd.start <= 1'b1;
          curHost   <= hPend;
          if (hPend) begin
            cmd.isRead  <= !hWr;
            cmd.phyAddr <= 5'(PHY_BASE) + 5'(hPort);
            cmd.regAddr <= hReg;
            cmd.wrData  <= hData;
          end else begin
            cmd.isRead  <= 1'b1;
            cmd.phyAddr <= 5'(PHY_BASE) + 5'(pollPort);
            cmd.regAddr <= pollRegOf(pollSlot);
            cmd.wrData  <= '0;
          end
          state <= S_WAIT;
        end
        default: begin
          if (rsp.done) begin
            state <= S_LAUNCH;
            if (curHost) begin
              hostDone  <= 1'b1;
              hPend     <= 1'b0;
              if (!hWr) hostRdata <= rsp.rdData;
            end else begin
              pollSlot <= pollSlot + 2'd1;
              if (pollSlot == 2'(POLL_SLOTS - 1))
                pollPort <= (pollPort == LAST_PORT) ? '0 : pollPort + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // Per-port shadow registers and status
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic       anEn;
    logic       frc100;
    logic       frcFull;
    logic [3:0] adv;
    logic       linkR;
    logic       spdR;
    logic       fullR;
    logic       resSpd;
    logic       resFull;
    logic       hit;

    assign hit = pollDone && (pollPort == PORT_W'(g));

    mdio_poll_resolve u_resolve (
      .autoNeg    (anEn),
      .forceSpd   (frc100),
      .forceFull  (frcFull),
      .localAbil  (adv),
      .peerAbil   (rsp.rdData[8:5]),
      .speed100   (resSpd),
      .fullDuplex (resFull)
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        anEn    <= 1'b0;
        frc100  <= 1'b0;
        frcFull <= 1'b0;
        adv     <= '0;
        linkR   <= 1'b0;
        spdR    <= 1'b0;
        fullR   <= 1'b0;
      end else if (hit) begin
        case (pollSlot)
          2'd0: begin
            anEn    <= rsp.rdData[12];
            frc100  <= rsp.rdData[13];
            frcFull <= rsp.rdData[8];
          end
          2'd1: linkR <= rsp.rdData[2];
          2'd2: adv   <= rsp.rdData[8:5];
          default: begin
            spdR  <= resSpd;
            fullR <= resFull;
          end
        endcase
      end
    end

    assign linkUp[g]     = linkR;
    assign speed100[g]   = spdR;
    assign fullDuplex[g] = fullR;
  end

  p_done_clears_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |-> !hostBusy);

  p_busy_ends_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostBusy) |-> hostDone);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);

  p_host_keeps_slot_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rsp.done && curHost && state == S_WAIT) |=> ($stable(pollPort) && $stable(pollSlot)));

  p_slot_advance_r5: assert property (@(posedge clk) disable iff (!rstN)
    pollDone |=> !$stable({pollPort, pollSlot}));

endmodule

// File: rtl/mdio_poll_master.sv
module mdio_poll_master
  import mdio_poll_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PHY_BASE  = 1,
  parameter int DIV_HALF  = 10,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostReq,
  input  logic                 hostWrite,
  input  logic [PORT_W-1:0]    hostPort,
  input  logic [4:0]           hostReg,
  input  logic [15:0]          hostWdata,
  output logic                 hostBusy,
  output logic                 hostDone,
  output logic [15:0]          hostRdata,
  output logic                 mdc,
  output logic                 mdioOut,
  output logic                 mdioOe,
  input  logic                 mdioIn,
  output logic [NUM_PORTS-1:0] linkUp,
  output logic [NUM_PORTS-1:0] fullDuplex,
  output logic [NUM_PORTS-1:0] speed100
);
  mdioCmd_t cmd;
  mdioRsp_t rsp;

  mdio_poll_ctrl #(
    .NUM_PORTS (NUM_PORTS),
    .PHY_BASE  (PHY_BASE),
    .PORT_W    (PORT_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostReq    (hostReq),
    .hostWrite  (hostWrite),
    .hostPort   (hostPort),
    .hostReg    (hostReg),
    .hostWdata  (hostWdata),
    .hostBusy   (hostBusy),
    .hostDone   (hostDone),
    .hostRdata  (hostRdata),
    .cmd        (cmd),
    .rsp        (rsp),
    .linkUp     (linkUp),
    .fullDuplex (fullDuplex),
    .speed100   (speed100)
  );

  mdio_poll_dpath #(
    .DIV_HALF (DIV_HALF)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .rsp     (rsp),
    .mdc     (mdc),
    .mdioOut (mdioOut),
    .mdioOe  (mdioOe),
    .mdioIn  (mdioIn)
  );
endmodule

// File: tb/test_mdio_poll_master.sv
`timescale 1ns/1ps
module test_mdio_poll_master;
  localparam int NP = 3;
  localparam int DH = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWrite = 1'b0;
  logic [1:0]  hostPort = '0;
  logic [4:0]  hostReg = '0;
  logic [15:0] hostWdata = '0;
  logic        hostBusy, hostDone;
  logic [15:0] hostRdata;
  logic        mdc, mdioOut, mdioOe, mdioIn;
  logic [NP-1:0] linkUp, fullDuplex, speed100;
  logic        phyDrv = 1'b1;

  assign mdioIn = mdioOe ? mdioOut : phyDrv;

  always #4 clk = ~clk;

  mdio_poll_master #(.NUM_PORTS(NP), .PHY_BASE(1), .DIV_HALF(DH)) i_mdio_poll_master (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostPort(hostPort), .hostReg(hostReg), .hostWdata(hostWdata),
    .hostBusy(hostBusy), .hostDone(hostDone), .hostRdata(hostRdata),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn),
    .linkUp(linkUp), .fullDuplex(fullDuplex), .speed100(speed100));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- PHY model ----------------
  logic [15:0] phyRegs [0:NP-1][0:31];
  int          ones = 0;
  bit          inFrame = 0;
  int          pos = 0;
  logic [1:0]  fSt, fOp;
  logic [4:0]  fPhy, fReg;
  logic [15:0] fData;
  int          fmtErr = 0;
  int          oeErr = 0;
  logic [4:0]  logPhy [0:1023];
  logic [4:0]  logReg [0:1023];
  bit          logWr  [0:1023];
  int          logCnt = 0;

  always @(posedge mdc) begin
    if (!inFrame) begin
      if (mdioOe && mdioOut) ones++;
      else if (mdioOe && !mdioOut && ones >= 32) begin
        if (ones != 32) fmtErr++;
        inFrame = 1; pos = 33; fSt = 2'b00; fOp = 2'b00;
      end else ones = 0;
    end else begin
      if (pos == 33) fSt = {1'b0, mdioOut};
      else if (pos == 34 || pos == 35) fOp = {fOp[0], mdioOut};
      else if (pos >= 36 && pos <= 40) fPhy = {fPhy[3:0], mdioOut};
      else if (pos >= 41 && pos <= 45) fReg = {fReg[3:0], mdioOut};
      if (pos == 36 && (fSt != 2'b01 || (fOp != 2'b10 && fOp != 2'b01))) fmtErr++;
      if (pos >= 46 && fOp == 2'b10 && mdioOe) oeErr++;
      if (fOp == 2'b01 && pos == 46 && !(mdioOe && mdioOut)) fmtErr++;
      if (fOp == 2'b01 && pos == 47 && !(mdioOe && !mdioOut)) fmtErr++;
      if (fOp == 2'b01 && pos >= 48) fData = {fData[14:0], mdioOut};
      if (pos == 63) begin
        if (fOp == 2'b01 && fPhy >= 1 && fPhy <= NP) phyRegs[fPhy-1][fReg] = fData;
        if (logCnt < 1024) begin
          logPhy[logCnt] = fPhy; logReg[logCnt] = fReg; logWr[logCnt] = (fOp == 2'b01);
          logCnt++;
        end
        inFrame = 0; ones = 0;
      end
      pos++;
    end
  end

  always @(negedge mdc) begin
    phyDrv = 1'b1;
    if (inFrame && fOp == 2'b10 && fPhy >= 1 && fPhy <= NP) begin
      if (pos == 47) phyDrv = 1'b0;
      else if (pos >= 48 && pos <= 63) phyDrv = phyRegs[fPhy-1][fReg][63-pos];
    end
  end

  // ---------------- MDC / MDIO timing monitor ----------------
  logic prevOut = 0, prevOe = 0, prevMdc = 0;
  int   stableErr = 0, highErr = 0, highLen = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (mdc && (mdioOut !== prevOut || mdioOe !== prevOe)) stableErr++;
      if (mdc) highLen++;
      else if (prevMdc) begin
        if (highLen != DH) highErr++;
        highLen = 0;
      end
    end
    prevOut = mdioOut; prevOe = mdioOe; prevMdc = mdc;
  end

  // ---------------- helpers ----------------
  function automatic logic [4:0] regOf(input int s);
    case (s)
      0: return 5'd0;
      1: return 5'd1;
      2: return 5'd4;
      default: return 5'd5;
    endcase
  endfunction

  function automatic int slotOf(input logic [4:0] r);
    case (r)
      5'd0: return 0;
      5'd1: return 1;
      5'd4: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] expMode(input logic [15:0] r0, r4, r5);
    logic [3:0] c;
    c = r4[8:5] & r5[8:5];
    if (!r0[12]) return {r0[13], r0[8]};
    if (c[3]) return 2'b11;
    if (c[2]) return 2'b10;
    if (c[1]) return 2'b01;
    return 2'b00;
  endfunction

  task automatic hostOp(input bit wr, input int port, input int rg,
                        input logic [15:0] wd, output logic [15:0] rd);
    int n;
    @(negedge clk);
    hostReq = 1; hostWrite = wr; hostPort = 2'(port); hostReg = 5'(rg); hostWdata = wd;
    @(negedge clk);
    hostReq = 0;
    check(hostBusy, "R10", "busy after request", hostBusy, 1);
    n = 0;
    while (!hostDone && n < 5000) begin @(negedge clk); n++; end
    check(hostDone && !hostBusy, "R10", "done with busy low", {hostDone, hostBusy}, 2);
    rd = hostRdata;
    @(negedge clk);
    check(!hostDone, "R10", "done single cycle", hostDone, 0);
  endtask

  task automatic checkResume(input int h);
    int n, prevSlot, expIdx;
    n = 0;
    while (logCnt <= h + 1 && n < 2000) begin @(negedge clk); n++; end
    prevSlot = (logPhy[h-1] - 1) * 4 + slotOf(logReg[h-1]);
    expIdx   = (prevSlot + 1) % (NP * 4);
    check(logPhy[h+1] == 5'(expIdx / 4 + 1) && logReg[h+1] == regOf(expIdx % 4) && !logWr[h+1],
          "R11", "poll resumes after host frame",
          {logPhy[h+1], logReg[h+1]}, {5'(expIdx / 4 + 1), regOf(expIdx % 4)});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog run did not complete actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    logic [15:0] rd;
    int h;
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < 32; r++) phyRegs[p][r] = 16'(p * 256 + r * 3);

    repeat (4) @(negedge clk);
    // R12 reset state
    check(!mdc && !mdioOe, "R12", "mdc/oe low in reset", {mdc, mdioOe}, 0);
    check(!hostBusy && !hostDone, "R12", "host flags low in reset", {hostBusy, hostDone}, 0);
    check(linkUp == 0 && fullDuplex == 0 && speed100 == 0, "R12", "status zero in reset",
          {linkUp, fullDuplex, speed100}, 0);
    rstN = 1;

    // R5 / R6 / R1 poll order
    while (logCnt < NP * 4) @(negedge clk);
    for (int k = 0; k < NP * 4; k++)
      check(logPhy[k] == 5'(k / 4 + 1) && logReg[k] == regOf(k % 4) && !logWr[k],
            "R5", "poll sequence entry", {logPhy[k], logReg[k]}, {5'(k / 4 + 1), regOf(k % 4)});

    // R7 / R8 / R9 status sweep
    for (int i = 0; i < 12; i++) begin
      for (int p = 0; p < NP; p++) begin
        int k;
        k = i * NP + p;
        phyRegs[p][0] = 16'((((k % 5) != 0) ? 1 : 0) << 12) | 16'((k % 2) << 13) | 16'(((k / 2) % 2) << 8);
        phyRegs[p][1] = 16'h7809 | 16'((((k % 3) != 1) ? 1 : 0) << 2);
        phyRegs[p][4] = 16'((k % 16) << 5) | 16'h0001;
        phyRegs[p][5] = 16'(((k * 7 + 5) % 16) << 5);
      end
      repeat (6600) @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        logic [1:0] m;
        m = expMode(phyRegs[p][0], phyRegs[p][4], phyRegs[p][5]);
        check(linkUp[p] == phyRegs[p][1][2], "R7", "link from register 1 bit 2",
              linkUp[p], phyRegs[p][1][2]);
        check({speed100[p], fullDuplex[p]} == m, phyRegs[p][0][12] ? "R8" : "R9",
              "speed/duplex resolution", {speed100[p], fullDuplex[p]}, m);
      end
    end

    // R3 / R6 host reads on every port
    for (int p = 0; p < NP; p++) begin
      phyRegs[p][2]  = 16'h1230 + 16'(p);
      phyRegs[p][29] = 16'h8001 ^ 16'(p << 4);
      hostOp(0, p, 2, 16'h0, rd);
      check(rd == phyRegs[p][2], "R3", "host read reg 2", rd, phyRegs[p][2]);
      h = logCnt - 1;
      check(logPhy[h] == 5'(p + 1) && logReg[h] == 5'd2 && !logWr[h], "R6",
            "host frame address", {logPhy[h], logReg[h]}, {5'(p + 1), 5'd2});
      hostOp(0, p, 29, 16'h0, rd);
      check(rd == phyRegs[p][29], "R3", "host read reg 29", rd, phyRegs[p][29]);
    end

    // R4 / R11 host write, then read back
    repeat (300) @(negedge clk);
    hostOp(1, 2, 9, 16'hA5C3, rd);
    h = logCnt - 1;
    check(phyRegs[2][9] == 16'hA5C3, "R4", "write reached PHY", phyRegs[2][9], 16'hA5C3);
    check(logWr[h] && logPhy[h] == 5'd3 && logReg[h] == 5'd9, "R1", "write frame fields",
          {logWr[h], logPhy[h], logReg[h]}, {1'b1, 5'd3, 5'd9});
    checkResume(h);
    hostOp(0, 2, 9, 16'h0, rd);
    check(rd == 16'hA5C3, "R4", "write read back", rd, 16'hA5C3);

    // R10 request while busy is ignored
    phyRegs[0][20] = 16'h0000;
    repeat (300) @(negedge clk);
    @(negedge clk);
    hostReq = 1; hostWrite = 1; hostPort = 2'd1; hostReg = 5'd3; hostWdata = 16'h5A5A;
    @(negedge clk);
    hostReq = 1; hostWrite = 1; hostPort = 2'd0; hostReg = 5'd20; hostWdata = 16'hBEEF;
    @(negedge clk);
    hostReq = 0;
    begin
      int n;
      n = 0;
      while (!hostDone && n < 5000) begin @(negedge clk); n++; end
    end
    h = logCnt - 1;
    checkResume(h);
    repeat (800) @(negedge clk);
    check(phyRegs[1][3] == 16'h5A5A, "R10", "first request written", phyRegs[1][3], 16'h5A5A);
    check(phyRegs[0][20] == 16'h0000, "R10", "request while busy ignored", phyRegs[0][20], 0);
    check(!hostBusy, "R10", "no pending request left", hostBusy, 0);

    // R1 / R2 / R3 monitors
    check(fmtErr == 0, "R1", "frame format errors", fmtErr, 0);
    check(oeErr == 0, "R3", "drive during read turnaround/data", oeErr, 0);
    check(stableErr == 0, "R2", "mdio change while mdc high", stableErr, 0);
    check(highErr == 0, "R2", "mdc high phase length", highErr, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule